// File: doc/BRIEF.md
# Register-Mapped Interrupt Controller

This block gathers up to 32 interrupt request lines into one interrupt line for a processor. A request that goes high is latched into a status register and stays there until software acknowledges it. An enable register masks the requests. The AND of the two forms the pending set, and a master enable gates the final output. Software reads and writes the controller through a plain 32-bit register port. Each register sits at a word-aligned byte offset. Reads are combinational from the current register state. A write takes effect on the clock edge where `bus_wr` is high.

Software can change the enables in three ways: it can write the whole register, set bits by writing ones to a set port, or clear bits by writing ones to a clear port. Because the set and clear ports only touch the bits written as 1, a handler can change its own enable without a read-modify-write. A vector register gives the index of the lowest-numbered pending request, which is also the most urgent one. While the block is in the software-test mode it comes up in, software may inject requests by writing to the status register. Setting the hardware-mode bit turns injection off, and only a reset can clear that bit again.

Top module: `irq_hub`

## Requirements
- R1: After reset, status, enable and master-control read 0, `irq_out` is 0, and the vector reads 0xFFFFFFFF.
- R2: If `irq_in[i]` is 1 at a clock edge, status bit i (offset 0x00) is 1 after that edge. It stays 1 after the input drops, until an acknowledge clears it.
- R3: The pending register (offset 0x04) reads status AND enable.
- R4: A write to offset 0x08 loads the whole enable register. Writing ones to offset 0x10 sets those enable bits, and writing ones to offset 0x14 clears them. Bits written as 0 through 0x10 or 0x14 leave the enable bits unchanged. Offsets 0x0C, 0x10 and 0x14 always read 0.
- R5: Writing a 1 to bit i at offset 0x0C clears status bit i. If `irq_in[i]` is 1 in that same cycle, the request wins and the bit stays 1.
- R6: The vector register (offset 0x18) reads the index of the lowest-numbered pending bit, or 0xFFFFFFFF if no bit is pending.
- R7: The master-control register (offset 0x1C) holds the master enable in bit 0 and the hardware-mode flag in bit 1. `irq_out` is 1 exactly when the master enable is 1 and at least one bit is pending.
- R8: While the hardware-mode flag is 0, a write to offset 0x00 ORs the written bits into status. Bits written as 0 are not cleared.
- R9: Once a write sets the hardware-mode flag, later writes to offset 0x00 have no effect. Later writes to offset 0x1C cannot clear the flag until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IRQ | Interrupt request lines, bit i is request i |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_out | output | 1 | Combined interrupt to the processor |

## Verification
Some behaviours are checked by the assertions on every cycle:
- a request sets its status bit on the next edge;
- a latched status bit never drops unless an acknowledge targets it;
- bits written through the set-enable port end up set;
- the hardware-mode flag never falls;
- the priority encoder never reports an index with a lower pending bit below it;
- `irq_out` never rises without a valid vector.

Other behaviours can only be shown by the bench's scenarios:
- the exact read values at each offset;
- the request-wins collision during an acknowledge;
- injection in software mode, and injection being ignored in hardware mode;
- vectors at the top bit.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int REG_W = 32;
  localparam int SEL_W = 3;
  localparam int SEL_LSB = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS  = 3'd0,
    SEL_PENDING = 3'd1,
    SEL_ENABLE  = 3'd2,
    SEL_ACK     = 3'd3,
    SEL_EN_SET  = 3'd4,
    SEL_EN_CLR  = 3'd5,
    SEL_VECTOR  = 3'd6,
    SEL_MASTER  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/irq_hub_status.sv
module irq_hub_status #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] req_in,
  input  logic [NUM_IRQ-1:0] sw_set,
  input  logic [NUM_IRQ-1:0] ack_mask,
  output logic [NUM_IRQ-1:0] status_q
);
  // Acknowledge first, then OR in the requests: in a collision the request wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~ack_mask) | req_in | sw_set;
  end

  // R2
  req_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(req_in)) == $past(req_in)));

  // R5
  no_spurious_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status_q) & ~$past(ack_mask)) & ~status_q) == '0));
endmodule

// File: rtl/irq_hub_enable.sv
module irq_hub_enable #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [NUM_IRQ-1:0] load_val,
  input  logic [NUM_IRQ-1:0] set_mask,
  input  logic [NUM_IRQ-1:0] clr_mask,
  output logic [NUM_IRQ-1:0] enable_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    enable_q <= '0;
    else if (load) enable_q <= load_val;
    else           enable_q <= (enable_q | set_mask) & ~clr_mask;
  end

  // R4
  set_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && (clr_mask == '0)) |=> ((enable_q & $past(set_mask)) == $past(set_mask)));
endmodule

// File: rtl/irq_hub_prio.sv
module irq_hub_prio #(
  parameter int NUM_IRQ = 32,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] pend,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  // Scan from the top down so the lowest set index is written last.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  // R6
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (pend[idx] && ((pend & ((NUM_IRQ'(1) << idx) - NUM_IRQ'(1))) == '0)));
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic               irq_out
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int MAP_BITS = SEL_LSB + SEL_W;

  logic               hit;
  reg_sel_e           sel;
  logic [NUM_IRQ-1:0] wdata_n;
  logic               unused_addr;
  logic               wr_status, wr_enable, wr_ack, wr_set, wr_clr, wr_master;
  logic [NUM_IRQ-1:0] status_q, enable_q, pending;
  logic               me_q, hie_q;
  logic               found;
  logic [IDX_W-1:0]   idx;
  logic [REG_W-1:0]   vector;

  assign hit         = (bus_addr >> MAP_BITS) == '0;
  assign sel         = reg_sel_e'(bus_addr[SEL_LSB +: SEL_W]);
  assign unused_addr = ^bus_addr[SEL_LSB-1:0];
  assign wdata_n     = bus_wdata[NUM_IRQ-1:0];

  always_comb begin
    wr_status = 1'b0; wr_enable = 1'b0; wr_ack = 1'b0;
    wr_set    = 1'b0; wr_clr    = 1'b0; wr_master = 1'b0;
    if (bus_wr && hit) begin
      unique case (sel)
        SEL_STATUS: wr_status = 1'b1;
        SEL_ENABLE: wr_enable = 1'b1;
        SEL_ACK:    wr_ack    = 1'b1;
        SEL_EN_SET: wr_set    = 1'b1;
        SEL_EN_CLR: wr_clr    = 1'b1;
        SEL_MASTER: wr_master = 1'b1;
        default: ;
      endcase
    end
  end

  irq_hub_status #(.NUM_IRQ(NUM_IRQ)) u_status (
    .clk(clk), .rst_n(rst_n), .req_in(irq_in),
    .sw_set((wr_status && !hie_q) ? wdata_n : '0),
    .ack_mask(wr_ack ? wdata_n : '0),
    .status_q(status_q)
  );

  irq_hub_enable #(.NUM_IRQ(NUM_IRQ)) u_enable (
    .clk(clk), .rst_n(rst_n), .load(wr_enable), .load_val(wdata_n),
    .set_mask(wr_set ? wdata_n : '0),
    .clr_mask(wr_clr ? wdata_n : '0),
    .enable_q(enable_q)
  );

  assign pending = status_q & enable_q;

  irq_hub_prio #(.NUM_IRQ(NUM_IRQ)) u_prio (
    .clk(clk), .rst_n(rst_n), .pend(pending), .found(found), .idx(idx)
  );

  assign vector = found ? REG_W'(idx) : '1;

  // Master enable follows writes; the hardware-mode flag can only rise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      me_q  <= 1'b0;
      hie_q <= 1'b0;
    end else if (wr_master) begin
      me_q <= bus_wdata[0];
      if (bus_wdata[1]) hie_q <= 1'b1;
    end
  end

  assign irq_out = me_q && (pending != '0);

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      unique case (sel)
        SEL_STATUS:  bus_rdata = REG_W'(status_q);
        SEL_PENDING: bus_rdata = REG_W'(pending);
        SEL_ENABLE:  bus_rdata = REG_W'(enable_q);
        SEL_VECTOR:  bus_rdata = vector;
        SEL_MASTER:  bus_rdata = {{(REG_W-2){1'b0}}, hie_q, me_q};
        default:     bus_rdata = '0;
      endcase
    end
  end

  // R9
  hw_mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hie_q |=> hie_q);

  // R7
  out_has_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (vector != '1 && me_q));
endmodule

// File: tb/test_irq_hub.sv
module test_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp_data;
    logic        exp_irq;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  irq_hub i_irq_hub (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // Monitor: pops the expected read value and compares it at the falling edge.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (bus_rdata !== it.exp_data || irq_out !== it.exp_irq) begin
        failures++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                 it.tag, bus_rdata, irq_out, it.exp_data, it.exp_irq);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected < 5000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic chk(input logic [4:0] a, input logic [31:0] d, input logic irq, input string tag);
    item_t it;
    @(posedge clk); #1;
    bus_addr = a; bus_wr = 1'b0;
    it.exp_data = d; it.exp_irq = irq; it.tag = tag;
    sb_q.push_back(it);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk(5'h00, 32'h0, 1'b0, "R1 status");
    chk(5'h08, 32'h0, 1'b0, "R1 enable");
    chk(5'h1C, 32'h0, 1'b0, "R1 master");
    chk(5'h18, 32'hFFFF_FFFF, 1'b0, "R1 vector");
    // R2 latch a one-cycle pulse
    @(posedge clk); #1 irq_in = 32'h24;
    @(posedge clk); #1 irq_in = '0;
    chk(5'h00, 32'h24, 1'b0, "R2 latched");
    chk(5'h04, 32'h0, 1'b0, "R3 masked");
    // R3 whole enable write
    wr(5'h08, 32'h20);
    chk(5'h04, 32'h20, 1'b0, "R3 pending");
    chk(5'h18, 32'd5, 1'b0, "R6 vector 5");
    // R4 set port
    wr(5'h10, 32'h4);
    chk(5'h08, 32'h24, 1'b0, "R4 set-enable");
    chk(5'h18, 32'd2, 1'b0, "R6 lowest wins");
    chk(5'h10, 32'h0, 1'b0, "R4 set reads 0");
    chk(5'h14, 32'h0, 1'b0, "R4 clr reads 0");
    chk(5'h0C, 32'h0, 1'b0, "R5 ack reads 0");
    // R7 master enable
    wr(5'h1C, 32'h1);
    chk(5'h1C, 32'h1, 1'b1, "R7 master on");
    // R4 clear port
    wr(5'h14, 32'h4);
    chk(5'h08, 32'h20, 1'b1, "R4 clr-enable");
    chk(5'h18, 32'd5, 1'b1, "R6 after clear");
    // R5 acknowledge
    wr(5'h0C, 32'h20);
    chk(5'h00, 32'h4, 1'b0, "R5 ack clears");
    chk(5'h18, 32'hFFFF_FFFF, 1'b0, "R6 none pending");
    // R5 collision: request held during acknowledge
    @(posedge clk); #1 irq_in = 32'h80;
    wr(5'h0C, 32'h80);
    chk(5'h00, 32'h84, 1'b0, "R5 request wins");
    irq_in = '0;
    wr(5'h0C, 32'h80);
    chk(5'h00, 32'h4, 1'b0, "R5 ack after drop");
    // R8 software injection
    wr(5'h00, 32'h0001_0000);
    chk(5'h00, 32'h0001_0004, 1'b0, "R8 inject");
    wr(5'h00, 32'h0);
    chk(5'h00, 32'h0001_0004, 1'b0, "R8 zero keeps");
    wr(5'h10, 32'h0001_0000);
    chk(5'h18, 32'd16, 1'b1, "R6 vector 16");
    wr(5'h00, 32'h8000_0000);
    wr(5'h10, 32'h8000_0000);
    wr(5'h0C, 32'h0001_0000);
    chk(5'h18, 32'd31, 1'b1, "R6 vector 31");
    chk(5'h04, 32'h8000_0000, 1'b1, "R3 top bit");
    // R9 hardware mode
    wr(5'h1C, 32'h3);
    chk(5'h1C, 32'h3, 1'b1, "R9 hw mode on");
    wr(5'h00, 32'h100);
    chk(5'h00, 32'h8000_0004, 1'b1, "R9 inject ignored");
    wr(5'h1C, 32'h1);
    chk(5'h1C, 32'h3, 1'b1, "R9 flag sticky");
    wr(5'h1C, 32'h0);
    chk(5'h1C, 32'h2, 1'b0, "R7 master off gates");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule